// File: doc/BRIEF.md
# Register-Controlled Two-Input Stream Switch

This block chooses which of two AXI4-Stream sources drives a single AXI4-Stream output. The output usually feeds a DMA engine, and the two sources are alternative processing engines. Beats pass through without a register stage. TDATA, TKEEP, TLAST and TVALID travel forward from the chosen source, and TREADY travels back to it. A source that is not chosen sees TREADY low, so it is held off and loses no data.

Software programs the route through a small AXI4-Lite style register port. It first writes a staged choice into the select register: a disable flag and a source index. It then writes the commit bit in the control register. The active route changes only at a packet boundary, so one packet is never built from two sources. Software can poll the commit bit to learn when the new route is in force.

Top module: `axisRouteSwitch`

## Requirements
- R1: After reset, the select register (offset 0x40) reads 0x8000_0000 and the control register (offset 0x00) reads 0. The output TVALID and both source TREADY lines are low.
- R2: While the active route is disabled, output TVALID is low and both source TREADY lines are low, whatever the inputs do.
- R3: While the active route is enabled, the output TDATA, TKEEP, TLAST and TVALID equal those of the selected source in the same cycle. The selected source's TREADY equals the output TREADY in the same cycle.
- R4: The source that is not selected always sees TREADY low.
- R5: A write to the select register changes only the staged value. The active route does not change until a commit is written.
- R6: Writing 1 to bit 1 of the control register (byte strobe 0 set) starts a commit. Bit 1 reads 1 until the route has been applied and 0 afterwards. Writes with bit 1 at 0 have no effect.
- R7: A commit is applied on the first clock edge after which no packet is open. That is either an edge with no beat in progress, or the edge that accepts a beat with TLAST set. The new route drives the ports from the cycle after that edge. A beat accepted without TLAST keeps the old route until the TLAST beat has been accepted.
- R8: The select register reads back the staged choice: bit 31 is the disable flag (1 = disabled) and bit 0 is the source index. All other bits read 0. Bit 31 is written only when byte strobe 3 is set, and bit 0 only when byte strobe 0 is set.
- R9: A write is accepted in a cycle where the address and data valids are both high and no response is outstanding. BVALID (response OKAY) rises in the next cycle and stays high until BREADY. A read is accepted when ARVALID is high and no read data is outstanding. RDATA is valid in the next cycle and stays stable until RREADY. Unmapped offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| s0Data | input | 32 | Source 0 TDATA |
| s0Keep | input | 4 | Source 0 TKEEP |
| s0Last | input | 1 | Source 0 TLAST |
| s0Valid | input | 1 | Source 0 TVALID |
| s0Ready | output | 1 | Source 0 TREADY |
| s1Data | input | 32 | Source 1 TDATA |
| s1Keep | input | 4 | Source 1 TKEEP |
| s1Last | input | 1 | Source 1 TLAST |
| s1Valid | input | 1 | Source 1 TVALID |
| s1Ready | output | 1 | Source 1 TREADY |
| mData | output | 32 | Output TDATA |
| mKeep | output | 4 | Output TKEEP |
| mLast | output | 1 | Output TLAST |
| mValid | output | 1 | Output TVALID |
| mReady | input | 1 | Output TREADY |
| awAddr | input | 7 | Write address |
| awValid | input | 1 | Write address valid |
| awReady | output | 1 | Write address ready |
| wData | input | 32 | Write data |
| wStrb | input | 4 | Write byte strobes |
| wValid | input | 1 | Write data valid |
| wReady | output | 1 | Write data ready |
| bResp | output | 2 | Write response |
| bValid | output | 1 | Write response valid |
| bReady | input | 1 | Write response ready |
| arAddr | input | 7 | Read address |
| arValid | input | 1 | Read address valid |
| arReady | output | 1 | Read address ready |
| rData | output | 32 | Read data |
| rResp | output | 2 | Read response |
| rValid | output | 1 | Read data valid |
| rReady | input | 1 | Read data ready |

## Verification
Stream forwarding is purely combinational, so the bench drives the source and output signals just after a falling edge. It samples the results one time unit later, in the same cycle, and withdraws the valids before the rising edge so that no beat is counted by accident. Register reads return data one cycle after acceptance, and the bench captures it at the falling edge that follows. A commit becomes visible on the ports in the cycle after the edge that closes the packet. The bench therefore checks that the old route still holds while a packet is open, and checks the new route only at the falling edge after the TLAST beat has been accepted.

// File: rtl/axisRoutePkg.sv
package axisRoutePkg;
  parameter int SLV_CNT  = 2;
  parameter int IDX_W    = (SLV_CNT > 1) ? $clog2(SLV_CNT) : 1;
  parameter int DATA_W   = 32;
  parameter int KEEP_W   = DATA_W / 8;
  parameter int ADDR_W   = 7;
  parameter int REG_W    = 32;

  localparam logic [ADDR_W-1:0] CTRL_OFF = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] SEL_OFF  = ADDR_W'('h40);
  localparam int COMMIT_BIT  = 1;
  localparam int DISABLE_BIT = REG_W - 1;

  // control -> datapath strobes
  typedef struct packed {
    logic             commitReq;
    logic             stagedDis;
    logic [IDX_W-1:0] stagedIdx;
  } routeCmdT;

  // datapath -> control strobes
  typedef struct packed {
    logic applied;
  } routeAckT;
endpackage

// File: rtl/routeCtrl.sv
module routeCtrl
  import axisRoutePkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   awAddr,
  input  logic                awValid,
  output logic                awReady,
  input  logic [REG_W-1:0]    wData,
  input  logic [REG_W/8-1:0]  wStrb,
  input  logic                wValid,
  output logic                wReady,
  output logic [1:0]          bResp,
  output logic                bValid,
  input  logic                bReady,
  input  logic [ADDR_W-1:0]   arAddr,
  input  logic                arValid,
  output logic                arReady,
  output logic [REG_W-1:0]    rData,
  output logic [1:0]          rResp,
  output logic                rValid,
  input  logic                rReady,
  output routeCmdT            cmd,
  input  routeAckT            ack
);
  localparam int STRB_W = REG_W / 8;
  localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(3);

  logic             stagedDis;
  logic [IDX_W-1:0] stagedIdx;
  logic             commitPending;
  logic             wrGo;
  logic             rdGo;
  logic             wrIsCtrl;
  logic             wrIsSel;
  logic             commitWrite;
  logic [REG_W-1:0] rdNext;

  assign wrGo     = awValid && wValid && !bValid;
  assign rdGo     = arValid && !rValid;
  assign awReady  = wrGo;
  assign wReady   = wrGo;
  assign arReady  = rdGo;
  assign bResp    = 2'b00;
  assign rResp    = 2'b00;

  assign wrIsCtrl    = (awAddr & WORD_MASK) == CTRL_OFF;
  assign wrIsSel     = (awAddr & WORD_MASK) == SEL_OFF;
  assign commitWrite = wrGo && wrIsCtrl && wStrb[0] && wData[COMMIT_BIT];

  // staged routing choice
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stagedDis <= 1'b1;
      stagedIdx <= '0;
    end else if (wrGo && wrIsSel) begin
      if (wStrb[STRB_W-1]) stagedDis <= wData[DISABLE_BIT];
      if (wStrb[0])        stagedIdx <= wData[IDX_W-1:0];
    end
  end

  // commit request: a new write wins over a same-cycle apply
  always_ff @(posedge clk) begin
    if (!rstN)            commitPending <= 1'b0;
    else if (commitWrite) commitPending <= 1'b1;
    else if (ack.applied) commitPending <= 1'b0;
  end

  assign cmd.commitReq = commitPending;
  assign cmd.stagedDis = stagedDis;
  assign cmd.stagedIdx = stagedIdx;

  // write response
  always_ff @(posedge clk) begin
    if (!rstN)       bValid <= 1'b0;
    else if (wrGo)   bValid <= 1'b1;
    else if (bReady) bValid <= 1'b0;
  end

  // read path
  always_comb begin
    rdNext = '0;
    if ((arAddr & WORD_MASK) == CTRL_OFF) begin
      rdNext[COMMIT_BIT] = commitPending;
    end else if ((arAddr & WORD_MASK) == SEL_OFF) begin
      rdNext[DISABLE_BIT] = stagedDis;
      rdNext[IDX_W-1:0]   = stagedIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rValid <= 1'b0;
      rData  <= '0;
    end else if (rdGo) begin
      rValid <= 1'b1;
      rData  <= rdNext;
    end else if (rReady) begin
      rValid <= 1'b0;
    end
  end

  // R6: an apply without a fresh commit write clears the pending flag
  assert_commit_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ack.applied && !commitWrite) |=> !commitPending);

  // R9: write response held until taken
  assert_bvalid_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (bValid && !bReady) |=> bValid);

  // R9: read data held stable until taken
  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && !rReady) |=> (rValid && $stable(rData)));
endmodule

// File: rtl/routeData.sv
module routeData
  import axisRoutePkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DATA_W-1:0]    sData [SLV_CNT],
  input  logic [KEEP_W-1:0]    sKeep [SLV_CNT],
  input  logic [SLV_CNT-1:0]   sLast,
  input  logic [SLV_CNT-1:0]   sValid,
  output logic [SLV_CNT-1:0]   sReady,
  output logic [DATA_W-1:0]    mData,
  output logic [KEEP_W-1:0]    mKeep,
  output logic                 mLast,
  output logic                 mValid,
  input  logic                 mReady,
  input  routeCmdT             cmd,
  output routeAckT             ack
);
  logic             activeDis;
  logic [IDX_W-1:0] activeIdx;
  logic             inPacket;
  logic             nextInPacket;
  logic             beatFire;
  logic             applyNow;
  logic             pickValid;

  // source multiplexer
  always_comb begin
    mData     = '0;
    mKeep     = '0;
    mLast     = 1'b0;
    pickValid = 1'b0;
    for (int i = 0; i < SLV_CNT; i++) begin
      if (activeIdx == IDX_W'(i)) begin
        mData     = sData[i];
        mKeep     = sKeep[i];
        mLast     = sLast[i];
        pickValid = sValid[i];
      end
    end
  end

  assign mValid = !activeDis && pickValid;

  generate
    for (genvar g = 0; g < SLV_CNT; g++) begin : gReady
      assign sReady[g] = !activeDis && (activeIdx == IDX_W'(g)) && mReady;
    end
  endgenerate

  // packet tracking and boundary-safe apply
  assign beatFire     = mValid && mReady;
  assign nextInPacket = beatFire ? !mLast : inPacket;
  assign applyNow     = cmd.commitReq && !nextInPacket;
  assign ack.applied  = applyNow;

  always_ff @(posedge clk) begin
    if (!rstN) inPacket <= 1'b0;
    else       inPacket <= nextInPacket;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeDis <= 1'b1;
      activeIdx <= '0;
    end else if (applyNow) begin
      activeDis <= cmd.stagedDis;
      activeIdx <= cmd.stagedIdx;
    end
  end

  // R2: disabled route is silent on both sides
  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    activeDis |-> (!mValid && (sReady == '0)));

  // R4: at most one source sees ready
  assert_one_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sReady));

  // R5: route changes only through an apply
  assert_route_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !ack.applied |=> ($stable(activeIdx) && $stable(activeDis)));

  // R7: a beat without TLAST never ends on a route change
  assert_no_split_R7: assert property (@(posedge clk) disable iff (!rstN)
    (beatFire && !mLast) |=> ($stable(activeIdx) && $stable(activeDis)));
endmodule

// File: rtl/axisRouteSwitch.sv
module axisRouteSwitch
  import axisRoutePkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [DATA_W-1:0]   s0Data,
  input  logic [KEEP_W-1:0]   s0Keep,
  input  logic                s0Last,
  input  logic                s0Valid,
  output logic                s0Ready,
  input  logic [DATA_W-1:0]   s1Data,
  input  logic [KEEP_W-1:0]   s1Keep,
  input  logic                s1Last,
  input  logic                s1Valid,
  output logic                s1Ready,
  output logic [DATA_W-1:0]   mData,
  output logic [KEEP_W-1:0]   mKeep,
  output logic                mLast,
  output logic                mValid,
  input  logic                mReady,
  input  logic [ADDR_W-1:0]   awAddr,
  input  logic                awValid,
  output logic                awReady,
  input  logic [REG_W-1:0]    wData,
  input  logic [REG_W/8-1:0]  wStrb,
  input  logic                wValid,
  output logic                wReady,
  output logic [1:0]          bResp,
  output logic                bValid,
  input  logic                bReady,
  input  logic [ADDR_W-1:0]   arAddr,
  input  logic                arValid,
  output logic                arReady,
  output logic [REG_W-1:0]    rData,
  output logic [1:0]          rResp,
  output logic                rValid,
  input  logic                rReady
);
  routeCmdT            cmd;
  routeAckT            ack;
  logic [DATA_W-1:0]   sData [SLV_CNT];
  logic [KEEP_W-1:0]   sKeep [SLV_CNT];
  logic [SLV_CNT-1:0]  sLast;
  logic [SLV_CNT-1:0]  sValid;
  logic [SLV_CNT-1:0]  sReady;

  assign sData[0] = s0Data;
  assign sData[1] = s1Data;
  assign sKeep[0] = s0Keep;
  assign sKeep[1] = s1Keep;
  assign sLast    = {s1Last, s0Last};
  assign sValid   = {s1Valid, s0Valid};
  assign s0Ready  = sReady[0];
  assign s1Ready  = sReady[1];

  routeCtrl uCtrl (
    .clk(clk), .rstN(rstN),
    .awAddr(awAddr), .awValid(awValid), .awReady(awReady),
    .wData(wData), .wStrb(wStrb), .wValid(wValid), .wReady(wReady),
    .bResp(bResp), .bValid(bValid), .bReady(bReady),
    .arAddr(arAddr), .arValid(arValid), .arReady(arReady),
    .rData(rData), .rResp(rResp), .rValid(rValid), .rReady(rReady),
    .cmd(cmd), .ack(ack)
  );

  routeData uData (
    .clk(clk), .rstN(rstN),
    .sData(sData), .sKeep(sKeep), .sLast(sLast),
    .sValid(sValid), .sReady(sReady),
    .mData(mData), .mKeep(mKeep), .mLast(mLast),
    .mValid(mValid), .mReady(mReady),
    .cmd(cmd), .ack(ack)
  );
endmodule

// File: tb/axisRouteSwitch_test.sv
module axisRouteSwitch_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] s0Data = '0, s1Data = '0;
  logic [3:0]  s0Keep = '0, s1Keep = '0;
  logic        s0Last = 1'b0, s1Last = 1'b0, s0Valid = 1'b0, s1Valid = 1'b0;
  logic        s0Ready, s1Ready;
  logic [31:0] mData;
  logic [3:0]  mKeep;
  logic        mLast, mValid;
  logic        mReady = 1'b0;
  logic [6:0]  awAddr = '0, arAddr = '0;
  logic        awValid = 1'b0, wValid = 1'b0, arValid = 1'b0;
  logic        bReady = 1'b1, rReady = 1'b1;
  logic [31:0] wData = '0;
  logic [3:0]  wStrb = '0;
  logic        awReady, wReady, bValid, arReady, rValid;
  logic [1:0]  bResp, rResp;
  logic [31:0] rData;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  axisRouteSwitch uut (.*);

  // vector: {sel, s0Valid, s1Valid, mReady}
  localparam logic [3:0] VECS [8] = '{
    4'b0101, 4'b0110, 4'b0011, 4'b0111,
    4'b1111, 4'b1010, 4'b1101, 4'b1001
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [6:0] addr, input logic [31:0] data, input logic [3:0] strb);
    @(negedge clk);
    awAddr = addr; wData = data; wStrb = strb; awValid = 1'b1; wValid = 1'b1;
    @(negedge clk);
    awValid = 1'b0; wValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic regRead(input logic [6:0] addr, output logic [31:0] data);
    @(negedge clk);
    arAddr = addr; arValid = 1'b1;
    @(negedge clk);
    arValid = 1'b0;
    data = rData;
    @(negedge clk);
  endtask

  task automatic idleStreams();
    s0Valid = 1'b0; s1Valid = 1'b0; mReady = 1'b0; s0Last = 1'b0; s1Last = 1'b0;
  endtask

  task automatic route(input logic dis, input logic idx);
    regWrite(7'h40, {dis, 30'b0, idx}, 4'hF);
    regWrite(7'h00, 32'h2, 4'h1);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    regRead(7'h40, rd); check("R1 sel reset", rd, 32'h8000_0000);
    regRead(7'h00, rd); check("R1 ctrl reset", rd, 32'h0);
    #1;
    check("R1 mValid", {31'b0, mValid}, 32'h0);
    check("R1 readies", {30'b0, s1Ready, s0Ready}, 32'h0);

    // R2: disabled route stays quiet under traffic
    @(negedge clk);
    s0Valid = 1; s1Valid = 1; mReady = 1; s0Last = 1; s1Last = 1;
    #1;
    check("R2 mValid disabled", {31'b0, mValid}, 32'h0);
    check("R2 readies disabled", {30'b0, s1Ready, s0Ready}, 32'h0);
    #1 idleStreams();

    // R5 / R8: staging without commit
    regWrite(7'h40, 32'h0000_0000, 4'hF);
    regRead(7'h40, rd); check("R8 staged enable readback", rd, 32'h0);
    @(negedge clk);
    s0Valid = 1; mReady = 1; s0Last = 1;
    #1;
    check("R5 no effect before commit", {30'b0, mValid, s0Ready}, 32'h0);
    #1 idleStreams();

    // R6: commit while idle applies and clears
    regWrite(7'h00, 32'h2, 4'h1);
    regRead(7'h00, rd); check("R6 commit cleared when idle", rd, 32'h0);

    // R3 / R4: vector walk
    for (int i = 0; i < 8; i++) begin
      logic sel, v0, v1, mr;
      logic [31:0] d0, d1;
      {sel, v0, v1, mr} = VECS[i];
      if (i == 0 || sel != VECS[i-1][3]) route(1'b0, sel);
      d0 = 32'hA000_0000 | i;
      d1 = 32'hB000_0000 | i;
      @(negedge clk);
      s0Data = d0; s1Data = d1; s0Keep = 4'hF; s1Keep = 4'h3;
      s0Last = i[0]; s1Last = ~i[0];
      s0Valid = v0; s1Valid = v1; mReady = mr;
      #1;
      check("R3 mValid", {31'b0, mValid}, {31'b0, sel ? v1 : v0});
      check("R3 mData", mData, sel ? d1 : d0);
      check("R3 mKeep", {28'b0, mKeep}, sel ? 32'h3 : 32'hF);
      check("R3 mLast", {31'b0, mLast}, {31'b0, sel ? ~i[0] : i[0]});
      check("R4 readies", {30'b0, s1Ready, s0Ready},
            {30'b0, sel & mr, ~sel & mr});
      #1 idleStreams();
    end

    // R7 / R6: commit during an open packet waits for TLAST
    route(1'b0, 1'b0);
    @(negedge clk);
    s0Valid = 1; s0Last = 0; mReady = 1; s0Data = 32'h1111_0001;
    @(negedge clk);
    idleStreams();
    regWrite(7'h40, 32'h0000_0001, 4'hF);
    regWrite(7'h00, 32'h2, 4'h1);
    regRead(7'h00, rd); check("R6 commit pending mid-packet", rd, 32'h2);
    @(negedge clk);
    s0Valid = 1; s1Valid = 1; mReady = 0; s0Data = 32'h1111_0002; s1Data = 32'h2222_0002;
    #1;
    check("R7 old route held", mData, 32'h1111_0002);
    check("R7 old route readies", {30'b0, s1Ready, s0Ready}, 32'h0);
    #1 mReady = 1; s0Last = 1;
    #1 check("R7 tlast beat ready", {30'b0, s1Ready, s0Ready}, 32'h1);
    @(negedge clk);
    s0Valid = 0; s0Last = 0; s1Data = 32'h2222_0003;
    #1;
    check("R7 new route data", mData, 32'h2222_0003);
    check("R7 new route readies", {30'b0, s1Ready, s0Ready}, 32'h2);
    #1 idleStreams();
    regRead(7'h00, rd); check("R6 commit cleared after tlast", rd, 32'h0);

    // R9: unmapped read, response hold
    regRead(7'h20, rd); check("R9 unmapped reads zero", rd, 32'h0);
    @(negedge clk);
    bReady = 0;
    awAddr = 7'h20; wData = 32'hFFFF_FFFF; wStrb = 4'hF; awValid = 1; wValid = 1;
    @(negedge clk);
    awValid = 0; wValid = 0;
    check("R9 bValid rises", {31'b0, bValid}, 32'h1);
    @(negedge clk);
    check("R9 bValid held", {31'b0, bValid}, 32'h1);
    bReady = 1;
    @(negedge clk);
    check("R9 bValid cleared", {31'b0, bValid}, 32'h0);

    // R8: field masks and strobes
    regWrite(7'h40, 32'hFFFF_FFFE, 4'hF);
    regRead(7'h40, rd); check("R8 masked readback", rd, 32'h8000_0000);
    regWrite(7'h40, 32'h0000_0001, 4'h1);
    regRead(7'h40, rd); check("R8 strobe keeps bit31", rd, 32'h8000_0001);

    // R6: write with bit1 low does not commit
    regWrite(7'h00, 32'h0, 4'h1);
    @(negedge clk);
    s1Valid = 1; mReady = 1; s1Last = 1;
    #1 check("R6 no commit without bit1", {31'b0, mValid}, 32'h1);
    #1 idleStreams();

    // R2: committed disable
    regWrite(7'h00, 32'h2, 4'h1);
    @(negedge clk);
    s0Valid = 1; s1Valid = 1; mReady = 1;
    #1;
    check("R2 disabled after commit", {29'b0, mValid, s1Ready, s0Ready}, 32'h0);
    #1 idleStreams();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule